// File: doc/BRIEF.md
# Synchronous Host Bus Register Slave

This block sits on a clocked microprocessor bus and gives the host read and write access to a small bank of registers. Chip select and the address strobe are both active low. When the strobe is low for one clock with chip select low, that clock is cycle T0. The block latches the address and the direction at T0. It then steps through T1 to T4 and answers in T5.

In T5 the block pulls its active-low transfer acknowledge low for one clock. On a write, it stores the data bus value into the addressed register on the edge that ends T5. On a read, it drives the register contents with a data enable during the same cycle.

The acknowledge is modelled as a value plus an output enable. The enable follows chip select, so the acknowledge line is released whenever chip select is high. If chip select rises before a cycle finishes, the cycle is abandoned.

Top module: `hbus_slave`

## Requirements
- R1: A clock edge that samples `strobe_n`=0 and `sel_n`=0 while the block is idle marks cycle T0. The edges that follow take the block through T1, T2, T3, T4 and T5.
- R2: `ack_n` is 0 for exactly the T5 clock. It is 1 during T1 to T4, and it stays 1 after T5 until `sel_n` rises.
- R3: `ack_oe` is 1 exactly when `sel_n` is 0, so the acknowledge is released whenever chip select is high.
- R4: On a write (`rd_nwr`=0 at T0), the `wdata` sampled on the edge that ends T5 is stored into the register addressed at T0.
- R5: On a read (`rd_nwr`=1 at T0), `rdata` carries the addressed register during T5 with `rdata_oe`=1. `rdata_oe` is 0 in every other cycle.
- R6: A strobe sampled while `sel_n`=1 starts no cycle, produces no acknowledge and writes nothing.
- R7: A strobe during an active cycle, or after T5 while chip select is still low, is ignored. The running cycle keeps its timing.
- R8: If `sel_n` rises before the T5 edge, the cycle is abandoned and no register changes.
- R9: `addr` and `rd_nwr` are latched at T0. Changes to them during T1 to T5 have no effect on the cycle.
- R10: A synchronous active-high `rst` returns the block to idle, makes `ack_n`=1 and clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_n | input | 1 | Address strobe, active low, one clock |
| sel_n | input | 1 | Chip select, active low |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Register address |
| wdata | input | DW | Write data bus |
| rdata | output | DW | Read data value |
| rdata_oe | output | 1 | Read data drive enable |
| ack_n | output | 1 | Transfer acknowledge value, active low |
| ack_oe | output | 1 | Acknowledge drive enable |

## Verification
The bench scrambles the address and direction after T0 on every cycle. A design that sampled them late would then store data into the wrong register or answer with the wrong kind of cycle.

Directed cases cover a number of timing faults:
- A strobe with chip select high would, in a faulty design, start a phantom cycle or corrupt a register.
- A second strobe mid-cycle would restart the counter and push the acknowledge late.
- Dropping chip select in T3 must leave the target register unchanged.
- Holding chip select after T5 exposes an acknowledge that repeats instead of staying high.
- Reading every register after a reset exposes a reset that misses the register bank.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4,
        PH_T5   = 3'd5,
        PH_HOLD = 3'd6
    } phase_t;

    function automatic phase_t next_phase(input phase_t p);
        return phase_t'(p + 3'd1);
    endfunction

    function automatic logic in_transit(input phase_t p);
        return (p == PH_T1) || (p == PH_T2) || (p == PH_T3) || (p == PH_T4);
    endfunction

endpackage

// File: rtl/hbus_seq.sv
module hbus_seq
    import hbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   strobe_n,
    input  logic   sel_n,
    output phase_t phase,
    output logic   start
);

    assign start = (phase == PH_IDLE) && !strobe_n && !sel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else if (sel_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE: if (!strobe_n) phase <= PH_T1;
                PH_T5:   phase <= PH_HOLD;
                PH_HOLD: phase <= PH_HOLD;
                default: phase <= next_phase(phase);
            endcase
        end
    end

    // R6
    idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && sel_n) |=> (phase == PH_IDLE));

    // R7
    steady_count_chk: assert property (@(posedge clk) disable iff (rst)
        (in_transit(phase) && !sel_n) |=> (phase == next_phase($past(phase))));

    // R7
    hold_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HOLD && !sel_n) |=> (phase == PH_HOLD));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (phase == PH_IDLE));

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int NREG = 1 << AW;

    logic [DW-1:0] mem [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (we && waddr == AW'(i))
                mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (mem[0] == '0));

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int AW = 3,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe_n,
    input  logic          sel_n,
    input  logic          rd_nwr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe,
    output logic          ack_n,
    output logic          ack_oe
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          is_rd;
    } cyc_t;

    phase_t phase;
    logic   start;
    cyc_t   cyc_q;
    logic   we;

    hbus_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (strobe_n),
        .sel_n    (sel_n),
        .phase    (phase),
        .start    (start)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cyc_q <= '{addr: '0, is_rd: 1'b1};
        else if (start)
            cyc_q <= '{addr: addr, is_rd: rd_nwr};
    end

    assign we = (phase == PH_T5) && !cyc_q.is_rd && !sel_n;

    hbus_regfile #(.AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (cyc_q.addr),
        .wdata (wdata),
        .raddr (cyc_q.addr),
        .rdata (rdata)
    );

    assign rdata_oe = (phase == PH_T5) && cyc_q.is_rd && !sel_n;
    assign ack_n    = (phase != PH_T5);
    assign ack_oe   = !sel_n;

    // R2
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_oe && !ack_n) |=> ack_n);

    // R5
    rd_drive_chk: assert property (@(posedge clk) disable iff (rst)
        rdata_oe |-> (ack_oe && !ack_n));

    // R3
    release_chk: assert property (@(posedge clk) disable iff (rst)
        sel_n |-> (!ack_oe && !rdata_oe));

endmodule

// File: tb/hbus_slave_bench.sv
module hbus_slave_bench;

    localparam int AW = 3;
    localparam int DW = 16;
    localparam int NREG = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe_n = 1'b1;
    logic          sel_n = 1'b1;
    logic          rd_nwr = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe, ack_n, ack_oe;

    int checks = 0;
    int fails = 0;
    logic [DW-1:0] model [NREG];

    always #2 clk = ~clk;

    hbus_slave #(.AW(AW), .DW(DW)) u_hbus_slave (
        .clk(clk), .rst(rst), .strobe_n(strobe_n), .sel_n(sel_n),
        .rd_nwr(rd_nwr), .addr(addr), .wdata(wdata), .rdata(rdata),
        .rdata_oe(rdata_oe), .ack_n(ack_n), .ack_oe(ack_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a);
        return model[a];
    endfunction

    // abort_at: 0 = full cycle, else sel_n released at that phase (1..4)
    task automatic bus_cycle(input logic rd, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input int abort_at,
                             input bit restrobe);
        @(negedge clk);
        sel_n = 1'b0; strobe_n = 1'b0; rd_nwr = rd; addr = a;
        @(posedge clk);                       // T0 edge (R1)
        @(negedge clk);                       // in T1
        strobe_n = 1'b1;
        addr = ~a; rd_nwr = ~rd;              // R9 scramble
        wdata = d;
        check("R2 ack high in T1", ack_n, 1'b1);
        for (int p = 1; p < 5; p++) begin
            if (abort_at == p) begin
                sel_n = 1'b1;
                #0;
                check("R3 released on abort", ack_oe, 1'b0);
                @(posedge clk);
                @(negedge clk);
                return;
            end
            if (restrobe && p == 2) strobe_n = 1'b0;  // R7
            @(posedge clk);
            @(negedge clk);
            strobe_n = 1'b1;
            if (p < 4) check("R2 ack high T2-T4", ack_n, 1'b1);
        end
        // now in T5
        check("R1 R2 ack low in T5", ack_n, 1'b0);
        check("R3 ack driven", ack_oe, 1'b1);
        check("R5 rdata_oe in T5", rdata_oe, rd);
        if (rd) check("R5 read value", rdata, expect_rd(a));
        else model[a] = d;
        strobe_n = 1'b0;                      // R7 strobe after T5, ignored
        @(posedge clk);
        @(negedge clk);
        strobe_n = 1'b1;
        check("R2 ack high after T5", ack_n, 1'b1);
        check("R5 no drive after T5", rdata_oe, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check("R7 no second ack", ack_n, 1'b1);
        sel_n = 1'b1;
        #0;
        check("R3 ack released", ack_oe, 1'b0);
        @(posedge clk);
    endtask

    initial begin
        #20000;
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R10 ack released at reset", ack_oe, 1'b0);
        sel_n = 1'b0;
        #0;
        check("R10 ack inactive after reset", ack_n, 1'b1);
        sel_n = 1'b1;

        bus_cycle(1'b1, 3'd2, '0, 0, 1'b0);          // R10 reads zero
        bus_cycle(1'b0, 3'd2, 16'hA5C3, 0, 1'b0);    // R4
        bus_cycle(1'b1, 3'd2, '0, 0, 1'b0);          // R5
        bus_cycle(1'b0, 3'd7, 16'h1234, 0, 1'b1);    // R7 restrobe in T2
        bus_cycle(1'b1, 3'd7, '0, 0, 1'b0);

        // R6: strobe with chip select high
        @(negedge clk);
        sel_n = 1'b1; strobe_n = 1'b0; rd_nwr = 1'b0; addr = 3'd2; wdata = 16'hFFFF;
        for (int k = 0; k < 6; k++) begin
            @(posedge clk);
            @(negedge clk);
            strobe_n = 1'b1;
            check("R6 no ack", ack_oe, 1'b0);
        end
        bus_cycle(1'b1, 3'd2, '0, 0, 1'b0);          // R6 register intact

        // R8: abort a write in T3
        bus_cycle(1'b0, 3'd7, 16'hDEAD, 3, 1'b0);
        bus_cycle(1'b1, 3'd7, '0, 0, 1'b0);          // R8 unchanged

        // random mix (R4 R5 R9)
        for (int n = 0; n < 60; n++) begin
            logic          r;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            r = 1'($urandom);
            a = AW'($urandom);
            d = DW'($urandom);
            bus_cycle(r, a, d, 0, 1'b0);
        end

        // R10: reset clears the bank
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NREG; i++) model[i] = '0;
        for (int i = 0; i < NREG; i++) bus_cycle(1'b1, AW'(i), '0, 0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule